// File: doc/BRIEF.md
# CPU-Paced DMA Read Handshake Engine

This block lets a processor pull bytes from a DMA-capable peripheral without a bus-master DMA controller. The peripheral raises its request line when it has data. Software then reads a data register inside a small two-register address window. Each such read runs one complete acknowledge handshake on the peripheral bus. The read strobe goes active first and the acknowledge follows. The byte the device presents is captured, then the acknowledge drops and the strobe drops last. While this runs, the processor is stalled through a ready line.

When the byte completes, the engine samples the request line again and records whether the device still wants service. Software polls this in a status register to decide whether to keep reading a block. A data read made while no request is pending starts no bus cycle. It returns all ones and sets a sticky underrun flag. The request input may pass through a configurable synchronizer. Each handshake phase lasts a configurable number of clocks.

Top module: `pdma_read_engine`

## Requirements
- R1: Out of reset, the strobe and acknowledge outputs are inactive (high), RDY is high, read data is 0x00 and the block-active and underrun flags are clear.
- R2: A read of the data register (window offset 0) starts a handshake only if the synchronized request is high at that clock edge. Otherwise the strobe and acknowledge stay inactive.
- R3: In a handshake the read strobe goes low one phase before the acknowledge goes low. Each of the four phases (strobe setup, acknowledge, sample, release) lasts PHASE_CYC clocks.
- R4: At the end of a byte the acknowledge returns high one phase before the read strobe returns high.
- R5: RDY is low for exactly 4*PHASE_CYC clocks per handshake and is low whenever the strobe is active.
- R6: The byte on the device data bus is captured in the last clock in which the acknowledge is low, and it is on the read data output when RDY returns high.
- R7: A data register read with the request low returns 0xFF, starts no strobe and sets the sticky underrun flag.
- R8: A status register read (window offset 1) returns bit0 = synchronized request level, bit1 = busy, bit2 = block-active, bit3 = underrun and zeros above. It clears the underrun flag.
- R9: The block-active flag is loaded at the end of every byte with the synchronized request level sampled in the final clock of the release phase.
- R10: Reads outside the window leave the read data and strobes unchanged. Reads presented while RDY is low are ignored.
- R11: A change on the raw request input reaches the status bit and the start decision after DRQ_SYNC_STAGES clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | Processor read address |
| cpu_rd | input | 1 | Read request, sampled on clock edges while RDY is high |
| cpu_rdata | output | DATA_W | Result of the last accepted window read |
| cpu_rdy | output | 1 | Processor ready; low stalls the processor during a handshake |
| isa_drq | input | 1 | Device service request, active high |
| isa_ior_n | output | 1 | Peripheral read strobe, active low |
| isa_dack_n | output | 1 | DMA acknowledge, active low |
| isa_data | input | DATA_W | Device data bus |

## Verification
The hardest state to reach is the end of the last byte of a block. There the device has already dropped its request during the acknowledge, and the synchronized level seen at the end of release must clear the block-active flag. The stimulus gets there with a bench device model that drops the request when it hands over its last queued byte. The same model holds the request high for earlier bytes. A second hard case is a read presented while the processor is stalled. The bench pulses a second data read in the middle of a handshake while the request is still high, and checks that no further strobe follows.

// File: rtl/pdma_pkg.sv
package pdma_pkg;

   typedef enum logic [2:0] {
      HS_IDLE,
      HS_SETUP,
      HS_ACK,
      HS_SMP,
      HS_REL
   } hs_state_e;

   localparam int ST_DRQ  = 0;
   localparam int ST_BUSY = 1;
   localparam int ST_BLK  = 2;
   localparam int ST_UND  = 3;
   localparam int ST_USED = 4;

endpackage

// File: rtl/pdma_drq_sync.sv
module pdma_drq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic drq_raw,
   output logic drq_s
);

   generate
      if (STAGES == 0) begin : g_direct
         assign drq_s = drq_raw;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= drq_raw;
               for (int i = 1; i < STAGES; i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign drq_s = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/pdma_win_decode.sv
module pdma_win_decode #(
   parameter int               ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'hDE40
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit_data,
   output logic              hit_stat
);

   logic in_win;

   assign in_win   = (addr[ADDR_W-1:1] == WIN_BASE[ADDR_W-1:1]);
   assign hit_data = in_win && !addr[0];
   assign hit_stat = in_win &&  addr[0];

endmodule

// File: rtl/pdma_hs_seq.sv
module pdma_hs_seq
   import pdma_pkg::*;
#(
   parameter int PHASE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic ior_n,
   output logic dack_n,
   output logic busy,
   output logic cap_en,
   output logic done
);

   localparam int CNT_W = $clog2(PHASE_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PHASE_CYC - 1);

   hs_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic             phase_end;

   assign phase_end = (cnt == CNT_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= HS_IDLE;
         cnt   <= '0;
      end else begin
         case (state)
            HS_IDLE: begin
               cnt <= '0;
               if (start) state <= HS_SETUP;
            end
            HS_SETUP, HS_ACK, HS_SMP, HS_REL: begin
               if (phase_end) begin
                  cnt <= '0;
                  case (state)
                     HS_SETUP: state <= HS_ACK;
                     HS_ACK:   state <= HS_SMP;
                     HS_SMP:   state <= HS_REL;
                     default:  state <= HS_IDLE;
                  endcase
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= HS_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign busy   = (state != HS_IDLE);
   assign ior_n  = !busy;
   assign dack_n = !((state == HS_ACK) || (state == HS_SMP));
   assign cap_en = (state == HS_SMP) && phase_end;
   assign done   = (state == HS_REL) && phase_end;

endmodule

// File: rtl/pdma_read_engine.sv
module pdma_read_engine
   import pdma_pkg::*;
#(
   parameter int                ADDR_W          = 16,
   parameter int                DATA_W          = 8,
   parameter logic [ADDR_W-1:0] WIN_BASE        = 16'hDE40,
   parameter int                PHASE_CYC       = 2,
   parameter int                DRQ_SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_rdy,
   input  logic              isa_drq,
   output logic              isa_ior_n,
   output logic              isa_dack_n,
   input  logic [DATA_W-1:0] isa_data
);

   generate
      if (PHASE_CYC < 1) begin : g_bad_phase
         $error("PHASE_CYC must be at least 1");
      end
      if (DATA_W < ST_USED) begin : g_bad_width
         $error("DATA_W too narrow for the status word");
      end
      if (DRQ_SYNC_STAGES < 0 || DRQ_SYNC_STAGES > 4) begin : g_bad_sync
         $error("DRQ_SYNC_STAGES must lie in 0..4");
      end
      if (WIN_BASE[0] != 1'b0) begin : g_bad_base
         $error("WIN_BASE must be even");
      end
   endgenerate

   logic              drq_s;
   logic              hit_data;
   logic              hit_stat;
   logic              busy;
   logic              cap_en;
   logic              done;
   logic              rd_ok;
   logic              start;
   logic              blk_q;
   logic              und_q;
   logic [DATA_W-1:0] rdata_q;
   logic [DATA_W-1:0] stat_word;

   pdma_drq_sync #(.STAGES(DRQ_SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .drq_raw (isa_drq),
      .drq_s   (drq_s)
   );

   pdma_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_dec (
      .addr     (cpu_addr),
      .hit_data (hit_data),
      .hit_stat (hit_stat)
   );

   assign rd_ok = cpu_rd && !busy;
   assign start = rd_ok && hit_data && drq_s;

   pdma_hs_seq #(.PHASE_CYC(PHASE_CYC)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .ior_n  (isa_ior_n),
      .dack_n (isa_dack_n),
      .busy   (busy),
      .cap_en (cap_en),
      .done   (done)
   );

   always_comb begin
      stat_word          = '0;
      stat_word[ST_DRQ]  = drq_s;
      stat_word[ST_BUSY] = busy;
      stat_word[ST_BLK]  = blk_q;
      stat_word[ST_UND]  = und_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         blk_q   <= 1'b0;
         und_q   <= 1'b0;
      end else begin
         if (cap_en) rdata_q <= isa_data;
         if (done)   blk_q   <= drq_s;
         if (rd_ok && hit_data && !drq_s) begin
            rdata_q <= '1;
            und_q   <= 1'b1;
         end
         if (rd_ok && hit_stat) begin
            rdata_q <= stat_word;
            und_q   <= 1'b0;
         end
      end
   end

   assign cpu_rdata = rdata_q;
   assign cpu_rdy   = !busy;

endmodule

module pdma_read_engine_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ior_n,
   input logic              dack_n,
   input logic              rdy,
   input logic              cpu_rd,
   input logic              hit_data,
   input logic              drq_s,
   input logic [DATA_W-1:0] rdata
);

   p_start_needs_drq_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ior_n) |-> ($past(drq_s) && $past(cpu_rd && hit_data)));

   p_ior_leads_dack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dack_n) |-> (!ior_n && $past(!ior_n)));

   p_dack_min_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dack_n) |=> !dack_n);

   p_dack_trails_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ior_n) |-> (dack_n && $past(dack_n)));

   p_rdy_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !ior_n |-> !rdy);

   p_underrun_ff_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && cpu_rd && hit_data && !drq_s) |=> (rdata == '1 && ior_n));

endmodule

bind pdma_read_engine pdma_read_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ior_n    (isa_ior_n),
   .dack_n   (isa_dack_n),
   .rdy      (cpu_rdy),
   .cpu_rd   (cpu_rd),
   .hit_data (hit_data),
   .drq_s    (drq_s),
   .rdata    (cpu_rdata)
);

// File: tb/pdma_read_engine_tb.sv
`timescale 1ns/1ps
module pdma_read_engine_tb_top;

   localparam int          P     = 2;
   localparam int          S     = 2;
   localparam logic [15:0] A_DAT = 16'hDE40;
   localparam logic [15:0] A_ST  = 16'hDE41;
   localparam int          WD    = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic        cpu_rd = 1'b0;
   logic [7:0]  cpu_rdata;
   logic        cpu_rdy;
   logic        isa_drq = 1'b0;
   logic        isa_ior_n;
   logic        isa_dack_n;
   logic [7:0]  isa_data = 8'h00;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   pdma_read_engine #(
      .ADDR_W(16), .DATA_W(8), .WIN_BASE(16'hDE40),
      .PHASE_CYC(P), .DRQ_SYNC_STAGES(S)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cpu_addr   (cpu_addr),
      .cpu_rd     (cpu_rd),
      .cpu_rdata  (cpu_rdata),
      .cpu_rdy    (cpu_rdy),
      .isa_drq    (isa_drq),
      .isa_ior_n  (isa_ior_n),
      .isa_dack_n (isa_dack_n),
      .isa_data   (isa_data)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, got, exp, cyc);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // Device: request is high while bytes are queued; a byte is handed over
   // when the acknowledge goes low, and the queue shrinks right then.
   logic [7:0] dev_q[$];
   bit in_ack = 0;
   always @(negedge clk) begin
      #1;
      if (!isa_dack_n && !in_ack) begin
         in_ack = 1;
         if (dev_q.size() != 0) isa_data = dev_q.pop_front();
      end else if (isa_dack_n) begin
         in_ack = 0;
         isa_data = 8'h00;
      end
      isa_drq = (dev_q.size() != 0);
   end

   // Behavioural reference: remaining-cycle counter and a request history.
   int       m_left = 0;
   logic [7:0] m_rdata = 8'h00;
   bit       m_blk = 0;
   bit       m_und = 0;
   bit       m_hist[0:7];
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_left = 0; m_rdata = 8'h00; m_blk = 0; m_und = 0;
         for (int k = 0; k < 8; k++) m_hist[k] = 0;
      end else begin
         bit seen;
         for (int k = 7; k > 0; k--) m_hist[k] = m_hist[k-1];
         m_hist[0] = isa_drq;
         seen = m_hist[S];
         if (m_left == 0) begin
            if (cpu_rd && cpu_addr == A_DAT) begin
               if (seen) m_left = 4*P;
               else begin m_rdata = 8'hFF; m_und = 1; end
            end else if (cpu_rd && cpu_addr == A_ST) begin
               m_rdata = {4'b0000, m_und, m_blk, 1'b0, seen};
               m_und = 0;
            end
         end else begin
            int pos;
            pos = 4*P - m_left;
            if (pos == 3*P-1) m_rdata = isa_data;
            if (pos == 4*P-1) m_blk = seen;
            m_left--;
         end
      end
      if (cyc > WD) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD);
         summary();
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int p;
         p = 4*P - m_left;
         chk("R2/R3", "ior_n", isa_ior_n, (m_left == 0));
         chk("R3/R4", "dack_n", isa_dack_n,
             (m_left == 0) ? 1 : !(p >= P && p < 3*P));
         chk("R5", "rdy", cpu_rdy, (m_left == 0));
         chk("R6/R7/R8", "rdata", cpu_rdata, m_rdata);
      end
   end

   task automatic cpu_read(input logic [15:0] a, output logic [7:0] d, output int lowcyc);
      @(negedge clk);
      cpu_addr = a; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      lowcyc = 0;
      while (!cpu_rdy) begin
         lowcyc++;
         @(negedge clk);
      end
      d = cpu_rdata;
   endtask

   initial begin
      logic [7:0] d;
      int lc;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      chk("R1", "ior_n at reset", isa_ior_n, 1);
      chk("R1", "dack_n at reset", isa_dack_n, 1);
      chk("R1", "rdy at reset", cpu_rdy, 1);
      chk("R1", "rdata at reset", cpu_rdata, 8'h00);
      cpu_read(A_ST, d, lc);
      chk("R1", "status after reset", d, 8'h00);

      // R7: underrun with request low, then R8 status clears it
      cpu_read(A_DAT, d, lc);
      chk("R7", "underrun data", d, 8'hFF);
      chk("R2", "no stall without request", lc, 0);
      cpu_read(A_ST, d, lc);
      chk("R8", "status after underrun", d, 8'h08);
      cpu_read(A_ST, d, lc);
      chk("R8", "underrun cleared by status read", d, 8'h00);

      // R11: request latency through the synchronizer
      dev_q.push_back(8'hA5);
      cpu_read(A_ST, d, lc);
      chk("R11", "request not yet visible", d, 8'h00);
      cpu_read(A_ST, d, lc);
      chk("R11", "request visible", d, 8'h01);

      // single byte; request drops during acknowledge
      cpu_read(A_DAT, d, lc);
      chk("R6", "single byte", d, 8'hA5);
      chk("R5", "stall length", lc, 4*P);
      cpu_read(A_ST, d, lc);
      chk("R9", "block flag clear after last byte", d, 8'h00);

      // three-byte block
      dev_q.push_back(8'h5A); dev_q.push_back(8'hFF); dev_q.push_back(8'h3C);
      repeat (4) @(negedge clk);
      cpu_read(A_DAT, d, lc);
      chk("R6", "block byte 1", d, 8'h5A);
      cpu_read(A_ST, d, lc);
      chk("R9", "block active after byte 1", d, 8'h05);
      cpu_read(A_DAT, d, lc);
      chk("R6", "block byte 2", d, 8'hFF);
      cpu_read(A_ST, d, lc);
      chk("R9", "block active after byte 2", d, 8'h05);
      cpu_read(A_DAT, d, lc);
      chk("R6", "block byte 3", d, 8'h3C);
      chk("R5", "stall length byte 3", lc, 4*P);
      cpu_read(A_ST, d, lc);
      chk("R9", "block ends", d, 8'h00);
      cpu_read(A_DAT, d, lc);
      chk("R7", "underrun after block", d, 8'hFF);
      cpu_read(A_ST, d, lc);
      chk("R8", "underrun sticky until status read", d, 8'h08);

      // R10: outside window and reads during a stall are ignored
      dev_q.push_back(8'h00); dev_q.push_back(8'hC3);
      repeat (4) @(negedge clk);
      cpu_read(16'h1234, d, lc);
      chk("R10", "outside window keeps rdata", d, 8'h08);
      chk("R10", "outside window no stall", lc, 0);
      @(negedge clk);
      cpu_addr = A_DAT; cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      @(negedge clk);
      chk("R10", "stalled before extra read", cpu_rdy, 0);
      cpu_rd = 1'b1;
      @(negedge clk);
      cpu_rd = 1'b0;
      while (!cpu_rdy) @(negedge clk);
      chk("R6", "zero byte", cpu_rdata, 8'h00);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk("R10", "no strobe from ignored read", isa_ior_n, 1);
      end
      cpu_read(A_DAT, d, lc);
      chk("R6", "drain byte", d, 8'hC3);
      repeat (4) @(negedge clk);
      summary();
   end

endmodule